// File: doc/BRIEF.md
# Power-On and Pin Reset Sequencer

This block produces the internal reset of a small microcontroller core. Two things can put the core into reset. The first is a power-up event, which is modelled here as a pulse on an input. The second is an active-low reset pin that is sampled through a two-flop synchronizer. After a power-up pulse the block counts a fixed number of machine cycles before it lets the core run. If the pin is held low, the block keeps the core in reset until the pin goes high again.

While reset is active, the block drives clear and set strobes and fixed values to the neighbouring registers:

- the stack pointer load value;
- the interrupt mask set;
- clears for the stop latch, the wait latch and the external interrupt latch;
- clears for every port direction bit;
- an AND/OR mask pair for the timer control byte.

The port output latches get no strobe and so keep their contents. The block also supplies the fixed addresses of the two vector bytes. It pulses a fetch strobe in the first cycle after reset ends, so the core knows when to start loading the vector. Only a power-up pulse starts the start-up delay. There is no supply monitoring.

Top module: `mcu_reset_gen`

## Requirements
- R1: After `por_i` falls, `core_rst_o` stays high through the first 1919 rising clock edges. It goes low after the 1920th edge, provided the pin has been high since at least two edges before that.
- R2: If `ext_rst_n_i` is still low when the 1920-cycle delay ends, `core_rst_o` stays high. It falls after the second rising edge that samples the pin high.
- R3: Once the delay has ended, a low level on `ext_rst_n_i` that is sampled by rising edge e sets `core_rst_o` high after edge e+1. It stays high for as long as the pin is sampled low.
- R4: A low pulse on `ext_rst_n_i` that begins and ends between two rising edges has no effect. `core_rst_o` stays low.
- R5: Pin reset does not restart the power-on delay. After the pin is sampled high at edge f, `core_rst_o` falls after edge f+1.
- R6: While `core_rst_o` is high, `tcr_and_o` is 8'h7F and `tcr_or_o` is 8'h40. This clears timer-control bit 7 (request) and sets bit 6 (mask). Otherwise these outputs are 8'hFF and 8'h00.
- R7: While `core_rst_o` is high, all of these are 1 and `sp_init_o` is 8'h7F: `sp_load_o`, `imask_set_o`, `ddr_clr_o`, `stop_clr_o`, `wait_clr_o` and `xirq_clr_o`. Otherwise all the strobes are 0.
- R8: `vec_hi_addr_o` is always 13'h1FFE and `vec_lo_addr_o` is always 13'h1FFF.
- R9: `vec_fetch_o` is high for exactly one cycle, the first cycle in which `core_rst_o` is low after having been high. It is low at all other times.
- R10: A rising `por_i` sets `core_rst_o` high at once, and this can happen at any time, including during a running delay. After `por_i` falls, the full 1920-cycle delay starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| por_i | input | 1 | Power-up pulse, active high, asynchronous |
| ext_rst_n_i | input | 1 | Reset pin, active low, asynchronous |
| core_rst_o | output | 1 | Internal core reset, active high |
| tcr_and_o | output | 8 | AND mask for timer control byte |
| tcr_or_o | output | 8 | OR mask for timer control byte |
| ddr_clr_o | output | 1 | Clear all port direction bits |
| sp_load_o | output | 1 | Load stack pointer |
| sp_init_o | output | 8 | Stack pointer value to load |
| imask_set_o | output | 1 | Set interrupt mask |
| stop_clr_o | output | 1 | Clear stop latch |
| wait_clr_o | output | 1 | Clear wait latch |
| xirq_clr_o | output | 1 | Clear external interrupt latch |
| vec_hi_addr_o | output | 13 | Address of vector high byte |
| vec_lo_addr_o | output | 13 | Address of vector low byte |
| vec_fetch_o | output | 1 | One-cycle strobe at reset release |

## Verification
The bench checks the edge at which the delay ends, at cycle 1919 and at cycle 1920. A counter that is off by one, or that starts at the wrong edge, releases the core one cycle early or late. It holds the pin low past the end of the delay and drops a second power-up pulse into the middle of a running delay. A design that ignores the pin at the end of the delay would release too early, and one that does not restart the count would release after fewer than 1920 cycles. It also checks the two-edge synchronizer latency in both directions, and that a glitch between edges is ignored. Finally it checks that a pin release returns control within two cycles rather than re-running the start-up delay.

// File: rtl/mcu_reset_gen.sv
module mcu_reset_gen #(
  parameter int unsigned DELAY   = 1920,
  parameter int unsigned AW      = 13,
  parameter logic [12:0] VEC_HI  = 13'h1FFE,
  parameter logic [7:0]  SP_INIT = 8'h7F,
  parameter int unsigned TCR_REQ = 7,
  parameter int unsigned TCR_MSK = 6
) (
  input  logic          clk,
  input  logic          por_i,
  input  logic          ext_rst_n_i,
  output logic          core_rst_o,
  output logic [7:0]    tcr_and_o,
  output logic [7:0]    tcr_or_o,
  output logic          ddr_clr_o,
  output logic          sp_load_o,
  output logic [7:0]    sp_init_o,
  output logic          imask_set_o,
  output logic          stop_clr_o,
  output logic          wait_clr_o,
  output logic          xirq_clr_o,
  output logic [AW-1:0] vec_hi_addr_o,
  output logic [AW-1:0] vec_lo_addr_o,
  output logic          vec_fetch_o
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  localparam logic [7:0] TCR_AND_RST = ~(8'd1 << TCR_REQ);
  localparam logic [7:0] TCR_OR_RST  = 8'd1 << TCR_MSK;

  logic          pin_s1, pin_s2;
  logic [CW-1:0] cnt;
  logic          rst_q;
  logic          delay_done;

  assign delay_done = (cnt == CW'(DELAY));
  assign core_rst_o = ~delay_done | ~pin_s2;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      pin_s1 <= 1'b0;
      pin_s2 <= 1'b0;
      cnt    <= '0;
      rst_q  <= 1'b1;
    end else begin
      pin_s1 <= ext_rst_n_i;
      pin_s2 <= pin_s1;
      if (!delay_done) cnt <= cnt + CW'(1);
      rst_q  <= core_rst_o;
    end
  end

  assign tcr_and_o   = core_rst_o ? TCR_AND_RST : 8'hFF;
  assign tcr_or_o    = core_rst_o ? TCR_OR_RST  : 8'h00;
  assign ddr_clr_o   = core_rst_o;
  assign sp_load_o   = core_rst_o;
  assign sp_init_o   = SP_INIT;
  assign imask_set_o = core_rst_o;
  assign stop_clr_o  = core_rst_o;
  assign wait_clr_o  = core_rst_o;
  assign xirq_clr_o  = core_rst_o;

  assign vec_hi_addr_o = AW'(VEC_HI);
  assign vec_lo_addr_o = AW'(VEC_HI) + AW'(1);
  assign vec_fetch_o   = rst_q & ~core_rst_o;
endmodule

// File: rtl/mcu_reset_gen_chk.sv
module mcu_reset_gen_chk #(
  parameter int unsigned DELAY = 1920
) (
  input logic clk,
  input logic por_i,
  input logic ext_rst_n_i,
  input logic core_rst_o,
  input logic vec_fetch_o
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  logic [CW-1:0] cyc;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) cyc <= '0;
    else if (cyc != CW'(DELAY)) cyc <= cyc + CW'(1);
  end

  // R1
  por_hold_chk: assert property (@(posedge clk) disable iff (por_i)
    (cyc != CW'(DELAY)) |-> core_rst_o);

  // R3
  pin_low_chk: assert property (@(posedge clk) disable iff (por_i)
    !$past(ext_rst_n_i, 2) |-> core_rst_o);

  // R9
  fetch_single_chk: assert property (@(posedge clk) disable iff (por_i)
    vec_fetch_o |=> !vec_fetch_o);

  // R9
  fetch_edge_chk: assert property (@(posedge clk) disable iff (por_i)
    vec_fetch_o |-> (!core_rst_o && $past(core_rst_o)));
endmodule

bind mcu_reset_gen mcu_reset_gen_chk #(.DELAY(DELAY)) u_chk (
  .clk(clk),
  .por_i(por_i),
  .ext_rst_n_i(ext_rst_n_i),
  .core_rst_o(core_rst_o),
  .vec_fetch_o(vec_fetch_o)
);

// File: tb/test_mcu_reset_gen.sv
module test_mcu_reset_gen;
  localparam int unsigned DLY = 1920;

  logic        clk = 1'b0;
  logic        por_i = 1'b1;
  logic        ext_rst_n_i = 1'b1;
  logic        core_rst_o;
  logic [7:0]  tcr_and_o, tcr_or_o, sp_init_o;
  logic        ddr_clr_o, sp_load_o, imask_set_o, stop_clr_o, wait_clr_o, xirq_clr_o;
  logic [12:0] vec_hi_addr_o, vec_lo_addr_o;
  logic        vec_fetch_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mcu_reset_gen i_mcu_reset_gen (
    .clk(clk), .por_i(por_i), .ext_rst_n_i(ext_rst_n_i),
    .core_rst_o(core_rst_o), .tcr_and_o(tcr_and_o), .tcr_or_o(tcr_or_o),
    .ddr_clr_o(ddr_clr_o), .sp_load_o(sp_load_o), .sp_init_o(sp_init_o),
    .imask_set_o(imask_set_o), .stop_clr_o(stop_clr_o), .wait_clr_o(wait_clr_o),
    .xirq_clr_o(xirq_clr_o), .vec_hi_addr_o(vec_hi_addr_o),
    .vec_lo_addr_o(vec_lo_addr_o), .vec_fetch_o(vec_fetch_o)
  );

  // pin, negedges to advance, expected core_rst, expected fetch
  typedef struct packed { logic pin; logic [7:0] n; logic rst; logic fetch; } vec_t;
  localparam vec_t VECS [9] = '{
    '{1'b0, 8'd1, 1'b0, 1'b0},
    '{1'b0, 8'd1, 1'b1, 1'b0},
    '{1'b0, 8'd5, 1'b1, 1'b0},
    '{1'b1, 8'd1, 1'b1, 1'b0},
    '{1'b1, 8'd1, 1'b0, 1'b1},
    '{1'b1, 8'd1, 1'b0, 1'b0},
    '{1'b0, 8'd2, 1'b1, 1'b0},
    '{1'b1, 8'd2, 1'b0, 1'b1},
    '{1'b1, 8'd3, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_strobes(input string req, input logic on);
    chk(req, {tcr_and_o, tcr_or_o}, on ? 32'h7F40 : 32'hFF00);
    chk(req, {ddr_clr_o, sp_load_o, imask_set_o, stop_clr_o, wait_clr_o, xirq_clr_o},
        on ? 32'h3F : 32'h0);
    chk(req, sp_init_o, 32'h7F);
  endtask

  task automatic chk_vec();
    chk("R8 hi", vec_hi_addr_o, 32'h1FFE);
    chk("R8 lo", vec_lo_addr_o, 32'h1FFF);
  endtask

  initial begin
    adv(3);
    chk("R10 rst during por", core_rst_o, 1);
    chk_strobes("R7 R6 in reset", 1'b1);
    chk("R9 no fetch in reset", vec_fetch_o, 0);
    chk_vec();
    por_i = 1'b0;
    adv(1919);
    chk("R1 still reset at 1919", core_rst_o, 1);
    adv(1);
    chk("R1 released at 1920", core_rst_o, 0);
    chk("R9 fetch pulse", vec_fetch_o, 1);
    adv(1);
    chk("R9 fetch single", vec_fetch_o, 0);
    chk_strobes("R6 R7 idle", 1'b0);
    chk_vec();

    // R3 R5 table walk
    foreach (VECS[i]) begin
      ext_rst_n_i = VECS[i].pin;
      adv(int'(VECS[i].n));
      chk("R3 R5 table rst", core_rst_o, VECS[i].rst);
      chk("R9 table fetch", vec_fetch_o, VECS[i].fetch);
      if (VECS[i].rst) chk_strobes("R6 R7 table", 1'b1);
    end

    // R4 glitch between edges
    ext_rst_n_i = 1'b0;
    #2 ext_rst_n_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      adv(1);
      chk("R4 glitch ignored", core_rst_o, 0);
    end

    // R2 pin held low beyond delay
    #1 por_i = 1'b1;
    #1 chk("R10 async por", core_rst_o, 1);
    ext_rst_n_i = 1'b0;
    adv(2);
    por_i = 1'b0;
    adv(DLY + 5);
    chk("R2 held by pin", core_rst_o, 1);
    ext_rst_n_i = 1'b1;
    adv(1);
    chk("R2 one edge after release", core_rst_o, 1);
    adv(1);
    chk("R2 released", core_rst_o, 0);
    chk("R9 fetch after pin", vec_fetch_o, 1);

    // R10 restart mid-delay
    por_i = 1'b1;
    adv(1);
    por_i = 1'b0;
    adv(1000);
    chk("R10 mid delay", core_rst_o, 1);
    por_i = 1'b1;
    adv(1);
    por_i = 1'b0;
    adv(DLY - 1);
    chk("R10 restart full count", core_rst_o, 1);
    adv(1);
    chk("R10 release after restart", core_rst_o, 0);
    chk_vec();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule